// File: doc/BRIEF.md
# Timer compare channel output generator

This block is one compare channel of a general-purpose timer. It contains its own up/down counter, a compare register with an optional shadow stage, and the logic that turns counter/compare relations into a single reference level. That level can later feed polarity or dead-time stages, which are not part of this block. A three-bit mode input selects what the level does: it can stay put, clear, set or invert on a counter/compare match. It can also be pinned low or high, or follow one of two direction-aware pulse-width schemes.

The counter reloads at the end of each counting period. Each reload, or a software update request, raises an update-event pulse for one cycle. With the shadow stage enabled, compare writes wait in the shadow register until that update. With it disabled, they land in the active compare register at once, so a later match in the same period already sees the new value.

Top module: `tmr_cmp_channel`

## Requirements
- R1: While `rst_n` is low, the counter, the active compare value, the shadow value, `oref` and `uev` are all 0.
- R2: With `tmr_en`=1 and `cnt_down`=0, the counter rises by one per cycle. At `reload_val` it wraps to 0 on the next edge, and `uev` is 1 for exactly the cycle after that edge.
- R3: With `tmr_en`=1 and `cnt_down`=1, the counter falls by one per cycle. At 0 it is loaded with `reload_val` on the next edge, and `uev` is 1 for the cycle after that edge.
- R4: With `tmr_en`=0 and no `sw_update`, the counter and `oref` keep their values and `uev` stays 0, whatever `mode` is.
- R5: `oref` is registered. While enabled, its value in a cycle depends on `mode`, the counter and the active compare value held in the previous cycle. Mode 3'b000 leaves `oref` unchanged, even on a match.
- R6: Mode 3'b001 drives `oref` to 0 on a match (counter equals active compare value). Mode 3'b010 drives it to 1 on a match. Without a match, both modes leave `oref` unchanged.
- R7: Mode 3'b011 inverts `oref` on every match.
- R8: Mode 3'b100 drives `oref` to 0 and mode 3'b101 drives it to 1, with no regard to counter or compare value.
- R9: Mode 3'b110 counting up gives 1 when counter < compare and 0 otherwise. Counting down, it gives 0 when counter > compare and 1 otherwise.
- R10: Mode 3'b111 gives the inverse of the 3'b110 level in every case.
- R11: With `preload_en`=0, a `cmp_wr` pulse places `cmp_val` into the active compare register on the next edge.
- R12: With `preload_en`=1, a `cmp_wr` pulse only fills the shadow register. The active compare value changes only on an update event, when it takes the shadow value.
- R13: `sw_update` makes the same edge load the counter with 0 (counting up) or `reload_val` (counting down) and make the preload transfer. `uev` then pulses even when `tmr_en`=0.
- R14: When a `cmp_wr` with `preload_en`=1 falls in the same cycle as an update event, the written `cmp_val` becomes the active compare value on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Counter and output run when 1 |
| mode | input | 3 | Output reference behaviour select |
| cnt_down | input | 1 | Counting direction, 1 = down |
| reload_val | input | W | Counting period end value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_val | input | W | Compare write data |
| preload_en | input | 1 | Route compare writes through the shadow register |
| sw_update | input | 1 | Software update request |
| oref | output | 1 | Channel output reference level |
| uev | output | 1 | Update-event pulse |

## Verification
Two functions can coincide: a compare write and an update event, from a counter wrap or from `sw_update`, may fall in the same cycle. Then both the shadow transfer and the direct write target the active compare register. The bench forces this in two ways. It waits until its own model shows the counter at the period end and issues the write in that cycle, and it also asserts `sw_update` together with `cmp_wr`. The outcome is judged through the match timing of `oref` in toggle mode on the following cycles, against the reference model's expected level.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD   = 3'b000,
        MODE_CLR    = 3'b001,
        MODE_SET    = 3'b010,
        MODE_TOGGLE = 3'b011,
        MODE_FORCE0 = 3'b100,
        MODE_FORCE1 = 3'b101,
        MODE_PWM_A  = 3'b110,
        MODE_PWM_B  = 3'b111
    } out_mode_e;

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmr_en,
    input  logic         cnt_down,
    input  logic [W-1:0] reload_val,
    input  logic         sw_update,
    output logic [W-1:0] cnt,
    output logic         upd_evt,
    output logic         uev
);
    localparam logic [W-1:0] STEP = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         uev;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_end;
    logic    wrap_evt;

    always_comb begin
        st_d     = st_q;
        at_end   = cnt_down ? (st_q.cnt == '0) : (st_q.cnt == reload_val);
        wrap_evt = tmr_en & at_end;
        upd_evt  = sw_update | wrap_evt;
        st_d.uev = upd_evt;
        if (upd_evt) begin
            st_d.cnt = cnt_down ? reload_val : '0;
        end else if (tmr_en) begin
            st_d.cnt = cnt_down ? (st_q.cnt - STEP) : (st_q.cnt + STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign uev = st_q.uev;

endmodule

// File: rtl/tcc_cmp_reg.sv
module tcc_cmp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_val,
    input  logic         preload_en,
    input  logic         upd_evt,
    output logic [W-1:0] cmp_act
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shadow;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmp_wr) begin
            st_d.shadow = cmp_val;
            if (!preload_en) begin
                st_d.act = cmp_val;
            end
        end
        if (upd_evt && preload_en) begin
            st_d.act = cmp_wr ? cmp_val : st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_act = st_q.act;

endmodule

// File: rtl/tcc_oref.sv
module tcc_oref
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmr_en,
    input  logic [2:0]   mode,
    input  logic         cnt_down,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    output logic         oref
);
    typedef struct packed {
        logic lvl;
    } ref_st_t;

    ref_st_t   st_d, st_q;
    out_mode_e sel;
    logic      hit;
    logic      below;
    logic      above;
    logic      pwm_a;

    always_comb begin
        st_d  = st_q;
        sel   = out_mode_e'(mode);
        hit   = (cnt == cmp_act);
        below = (cnt < cmp_act);
        above = (cnt > cmp_act);
        pwm_a = cnt_down ? ~above : below;
        if (tmr_en) begin
            unique case (sel)
                MODE_HOLD:   st_d.lvl = st_q.lvl;
                MODE_CLR:    if (hit) st_d.lvl = 1'b0;
                MODE_SET:    if (hit) st_d.lvl = 1'b1;
                MODE_TOGGLE: if (hit) st_d.lvl = ~st_q.lvl;
                MODE_FORCE0: st_d.lvl = 1'b0;
                MODE_FORCE1: st_d.lvl = 1'b1;
                MODE_PWM_A:  st_d.lvl = pwm_a;
                MODE_PWM_B:  st_d.lvl = ~pwm_a;
                default:     st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oref = st_q.lvl;

endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmr_en,
    input  logic [2:0]   mode,
    input  logic         cnt_down,
    input  logic [W-1:0] reload_val,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_val,
    input  logic         preload_en,
    input  logic         sw_update,
    output logic         oref,
    output logic         uev
);
    logic [W-1:0] cnt_now;
    logic [W-1:0] cmp_act;
    logic         upd_evt;

    tcc_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_en     (tmr_en),
        .cnt_down   (cnt_down),
        .reload_val (reload_val),
        .sw_update  (sw_update),
        .cnt        (cnt_now),
        .upd_evt    (upd_evt),
        .uev        (uev)
    );

    tcc_cmp_reg #(.W(W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_wr     (cmp_wr),
        .cmp_val    (cmp_val),
        .preload_en (preload_en),
        .upd_evt    (upd_evt),
        .cmp_act    (cmp_act)
    );

    tcc_oref #(.W(W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_en   (tmr_en),
        .mode     (mode),
        .cnt_down (cnt_down),
        .cnt      (cnt_now),
        .cmp_act  (cmp_act),
        .oref     (oref)
    );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tmr_en,
    input logic [2:0]   mode,
    input logic         cnt_down,
    input logic [W-1:0] reload_val,
    input logic         cmp_wr,
    input logic [W-1:0] cmp_val,
    input logic         preload_en,
    input logic         sw_update,
    input logic [W-1:0] cnt_now,
    input logic [W-1:0] cmp_act,
    input logic         upd_evt,
    input logic         oref,
    input logic         uev
);
    assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && !cnt_down && !sw_update && cnt_now == reload_val) |=> (cnt_now == '0 && uev));

    assert_reload_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && cnt_down && !sw_update && cnt_now == '0) |=> (cnt_now == $past(reload_val) && uev));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !sw_update) |=> ($stable(cnt_now) && $stable(oref) && !uev));

    assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && mode == 3'b100) |=> !oref);

    assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && mode == 3'b101) |=> oref);

    assert_direct_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !preload_en) |=> (cmp_act == $past(cmp_val)));

    assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !cmp_wr && !upd_evt) |=> $stable(cmp_act));

    assert_sw_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sw_update |=> uev);

    assert_write_on_update_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && preload_en && upd_evt) |=> (cmp_act == $past(cmp_val)));

endmodule

bind tmr_cmp_channel tcc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_en     (tmr_en),
    .mode       (mode),
    .cnt_down   (cnt_down),
    .reload_val (reload_val),
    .cmp_wr     (cmp_wr),
    .cmp_val    (cmp_val),
    .preload_en (preload_en),
    .sw_update  (sw_update),
    .cnt_now    (cnt_now),
    .cmp_act    (cmp_act),
    .upd_evt    (upd_evt),
    .oref       (oref),
    .uev        (uev)
);

// File: tb/sim_tmr_cmp_channel.sv
`timescale 1ns/1ps
module sim_tmr_cmp_channel;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tmr_en = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic         cnt_down = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_val = '0;
    logic         preload_en = 1'b0;
    logic         sw_update = 1'b0;
    logic         oref;
    logic         uev;

    int    vectors = 0;
    int    misses = 0;
    bit    done = 1'b0;
    string cur_req = "R1 reset";

    // behavioural reference state
    int unsigned m_cnt = 0, m_act = 0, m_sh = 0;
    bit m_oref = 0, m_uev = 0;

    always #5 clk = ~clk;

    tmr_cmp_channel #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode),
        .cnt_down(cnt_down), .reload_val(reload_val), .cmp_wr(cmp_wr),
        .cmp_val(cmp_val), .preload_en(preload_en), .sw_update(sw_update),
        .oref(oref), .uev(uev)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_sh = 0; m_oref = 0; m_uev = 0;
        end else begin
            int unsigned top, c, a, nc, na, ns;
            bit end_hit, upd, hit, lvl1, no;
            top = int'(reload_val); c = m_cnt; a = m_act;
            end_hit = tmr_en && (cnt_down ? (c == 0) : (c == top));
            upd = sw_update || end_hit;
            if (upd) nc = cnt_down ? top : 0;
            else if (tmr_en) nc = cnt_down ? ((c + 65535) % 65536) : ((c + 1) % 65536);
            else nc = c;
            ns = cmp_wr ? int'(cmp_val) : m_sh;
            na = a;
            if (cmp_wr && !preload_en) na = int'(cmp_val);
            if (upd && preload_en) na = cmp_wr ? int'(cmp_val) : m_sh;
            hit = (c == a);
            lvl1 = cnt_down ? !(c > a) : (c < a);
            no = m_oref;
            if (tmr_en) begin
                case (mode)
                    3'd1: if (hit) no = 0;
                    3'd2: if (hit) no = 1;
                    3'd3: if (hit) no = !m_oref;
                    3'd4: no = 0;
                    3'd5: no = 1;
                    3'd6: no = lvl1;
                    3'd7: no = !lvl1;
                    default: no = m_oref;
                endcase
            end
            m_cnt = nc; m_act = na; m_sh = ns; m_oref = no; m_uev = upd;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (oref !== m_oref || uev !== m_uev) begin
                misses++;
                $display("FAIL %s: oref=%b uev=%b expected oref=%b uev=%b",
                         cur_req, oref, uev, m_oref, m_uev);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input int v);
        cmp_wr = 1'b1; cmp_val = W'(v);
        step(1);
        cmp_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        cur_req = "R1 reset";
        step(3);
        if (oref !== 1'b0 || uev !== 1'b0) begin
            misses++;
            $display("FAIL R1: oref=%b uev=%b expected 0 0", oref, uev);
        end
        vectors++;
        rst_n = 1'b1;
        step(2);

        cur_req = "R2 up count wrap";
        reload_val = 16'd5; tmr_en = 1'b1; mode = 3'b000;
        step(20);

        cur_req = "R7 toggle on match";
        mode = 3'b011;
        write_cmp(2);
        step(20);

        cur_req = "R11 immediate compare write";
        write_cmp(4);
        step(3);
        write_cmp(1);
        step(12);

        cur_req = "R6 clear on match";
        mode = 3'b010; step(8);
        mode = 3'b001; step(8);
        mode = 3'b010; step(8);

        cur_req = "R5 hold on match";
        mode = 3'b000; step(14);

        cur_req = "R8 forced levels";
        mode = 3'b101; step(5);
        mode = 3'b100; step(5);
        mode = 3'b101; step(3);

        cur_req = "R9 pwm A up";
        mode = 3'b110; reload_val = 16'd7; write_cmp(3);
        step(20);
        cur_req = "R3 down count reload";
        cnt_down = 1'b1; step(20);
        cur_req = "R9 pwm A down";
        write_cmp(0); step(10);
        write_cmp(7); step(10);

        cur_req = "R10 pwm B";
        mode = 3'b111; write_cmp(4); step(18);
        cnt_down = 1'b0; step(18);

        cur_req = "R12 preload shadow";
        mode = 3'b011; preload_en = 1'b1;
        write_cmp(6); step(4); write_cmp(2);
        step(24);

        cur_req = "R13 software update";
        step(2); sw_update = 1'b1; step(1); sw_update = 1'b0;
        write_cmp(5); step(3);
        cnt_down = 1'b1; sw_update = 1'b1; step(1); sw_update = 1'b0;
        step(6);

        cur_req = "R4 disabled hold";
        tmr_en = 1'b0; mode = 3'b101; step(6);
        mode = 3'b110; write_cmp(3); step(4);
        cur_req = "R13 update while stopped";
        sw_update = 1'b1; step(1); sw_update = 1'b0; step(4);
        tmr_en = 1'b1; mode = 3'b011; cnt_down = 1'b0; step(10);

        cur_req = "R14 write on wrap";
        while (m_cnt != int'(reload_val)) step(1);
        write_cmp(1);
        step(20);
        cur_req = "R14 write with sw update";
        cmp_wr = 1'b1; cmp_val = 16'd4; sw_update = 1'b1;
        step(1);
        cmp_wr = 1'b0; sw_update = 1'b0;
        step(20);

        cur_req = "R14 mixed stimulus";
        seed = 7;
        for (int i = 0; i < 600; i++) begin
            tmr_en     = ($urandom(seed) % 8) != 0;
            seed       = seed + 1;
            mode       = 3'($urandom % 8);
            cnt_down   = ($urandom % 16) == 0 ? ~cnt_down : cnt_down;
            reload_val = ($urandom % 32) == 0 ? W'($urandom % 9) : reload_val;
            cmp_wr     = ($urandom % 6) == 0;
            cmp_val    = W'($urandom % 10);
            preload_en = ($urandom % 20) == 0 ? ~preload_en : preload_en;
            sw_update  = ($urandom % 25) == 0;
            step(1);
        end
        cmp_wr = 1'b0; sw_update = 1'b0;
        step(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule